// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block steps the memory addresses and tracks the remaining transfer counts for a small group of DMA channels that move data between memory and paired serial-port buffers. Software programs four fields for each channel through a single register-write port: a 19-bit index, a signed 16-bit modify step, a 16-bit count and an enable bit. Once the count is written and the channel is enabled, every request from the peripheral side is serviced with one memory access. After that access, the index moves by the modify step and the count drops by one.

When several channels request in the same cycle, a fixed-priority arbiter grants exactly one of them. Channels are grouped in pairs, one pair per pair of serial ports. Inside a pair, the odd-numbered channel wins. Between pairs, the pair with the lower number wins. The address that leaves the block is the index, wrapped within a 19-bit space, plus a fixed base offset. A count written as zero is not a stop command: it asks for the full 65536 transfers. A channel is stopped only by clearing its enable bit, or by running its count out.

Top module: `dma_seq`

## Requirements
- R1: While reset is held and just after it is released, `acc_valid` and every `done` bit are low, and requests cause no access until a channel has been given a count and enabled.
- R2: A channel whose `req` bit is high, whose enable bit is set and whose count has been written but not exhausted receives an access in that same cycle. In that cycle `acc_valid` is high, `acc_ch` carries the channel number, `acc_addr` equals BASE_ADDR plus the channel's index, and no more than one access is granted per cycle.
- R3: After each access the index becomes (index + sign-extended modify) mod 2^19. For example, index 0x7FFFF with modify 1 wraps to index 0, which is emitted as address 0x80000.
- R4: A negative modify written in two's complement moves the index downward, also wrapping mod 2^19. For example, index 1 with modify 0xFFFE (-2) becomes 0x7FFFF, which is emitted as address 0xFFFFF.
- R5: A count N between 1 and 65535 yields exactly N accesses. `done[ch]` is high for exactly one cycle: the cycle after the last access. After that the channel grants nothing until its count is written again.
- R6: A count written as 0 yields 65536 accesses before the `done` pulse, because the first access is made before the count is tested.
- R7: While a channel's enable bit is clear, its requests produce no access, and its index and count are left unchanged. Clearing the enable bit is the only way to stop a channel that still has count remaining.
- R8: Within a pair (channels 2p and 2p+1), the odd-numbered channel is granted when both are eligible.
- R9: Between pairs, every eligible channel of a lower-numbered pair is granted ahead of any channel of a higher-numbered pair. With 4 channels the priority order is 1, 0, 3, 2.
- R10: A register write is selected by `wr_sel`: 0 writes the index (`wr_data[18:0]`), 1 writes the modify value (`wr_data[15:0]`), 2 writes the count (`wr_data[15:0]`) and re-arms the channel, 3 writes control (`wr_data[0]` is the enable bit). The write takes effect at the next clock edge. When it hits a field that the same cycle's access would update, the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NCH (4) | Per-channel transfer request from the serial-port side |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CH_W (2) | Channel selected by the write |
| wr_sel | input | 2 | Field selected by the write (0 index, 1 modify, 2 count, 3 control) |
| wr_data | input | IDX_W (19) | Write data |
| acc_valid | output | 1 | A memory access is issued this cycle |
| acc_ch | output | CH_W (2) | Channel that owns the access |
| acc_addr | output | ADDR_W (20) | Memory address of the access |
| done | output | NCH (4) | One-cycle pulse per channel when its count runs out |

## Verification
The assertions are checked on every cycle. They confirm that each grant goes to a requesting, enabled and armed channel, and that no eligible request is left idle. They confirm that every emitted address lies inside the base window, and that the index of the channel served in the previous cycle moved by exactly its sign-extended modify unless a write replaced it. They also confirm that each done pulse lasts a single cycle and leaves its channel disarmed. Some behaviour can only be shown by the bench's scenarios: the exact numbers of accesses for a count of N and for a count of zero, the priority order between specific combinations of requests, and the fact that a disabled channel's state is left intact. The bench also shows that a write made in the same cycle as an access wins over that access's update.

// File: rtl/dma_seq_pkg.sv
// Package: shared field selectors for the DMA sequencer register port.
// Assumes: wr_sel is two bits wide and every encoding is used.
package dma_seq_pkg;
    typedef enum logic [1:0] {
        SEL_INDEX  = 2'd0,
        SEL_MODIFY = 2'd1,
        SEL_COUNT  = 2'd2,
        SEL_CTRL   = 2'd3
    } field_sel_e;
endpackage

// File: rtl/dma_seq_chan.sv
// Module: one channel's parameter state (index, modify, count, enable,
// armed) and its done pulse.
// Assumes: IDX_W >= MOD_W and IDX_W >= CNT_W. The write data is IDX_W bits
// wide. 'take' is high only in a cycle where this channel was granted.
module dma_seq_chan
    import dma_seq_pkg::*;
#(
    parameter int IDX_W = 19,
    parameter int MOD_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [1:0]       wr_sel,
    input  logic [IDX_W-1:0] wr_data,
    input  logic             take,
    output logic [IDX_W-1:0] idx_o,
    output logic [MOD_W-1:0] mod_o,
    output logic             en_o,
    output logic             armed_o,
    output logic             done_o
);
    localparam int EXT_W = IDX_W - MOD_W;

    logic [IDX_W-1:0] idx_q;
    logic [MOD_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt_q;
    logic             en_q;
    logic             armed_q;
    logic             done_q;
    logic [IDX_W-1:0] step;
    logic             wr_idx, wr_mod, wr_cnt, wr_ctl;
    logic             last_xfer;

    // Decode which field the current write targets.
    always_comb begin
        wr_idx = wr_hit && (wr_sel == SEL_INDEX);
        wr_mod = wr_hit && (wr_sel == SEL_MODIFY);
        wr_cnt = wr_hit && (wr_sel == SEL_COUNT);
        wr_ctl = wr_hit && (wr_sel == SEL_CTRL);
    end

    // Sign-extend the modify step to index width; the sum wraps mod 2^IDX_W.
    always_comb step = {{EXT_W{mod_q[MOD_W-1]}}, mod_q};

    // An access whose count is about to go from 1 to 0 ends the block.
    always_comb last_xfer = take && (cnt_q == CNT_W'(1));

    // Index register: a write wins over the post-access advance.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (wr_idx) idx_q <= wr_data;
        else if (take)   idx_q <= idx_q + step;
    end

    // Modify and enable registers, written only by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= '0;
            en_q  <= 1'b0;
        end else begin
            if (wr_mod) mod_q <= wr_data[MOD_W-1:0];
            if (wr_ctl) en_q  <= wr_data[0];
        end
    end

    // Count register: decremented after each access; 0 wraps to all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wr_data[CNT_W-1:0];
        else if (take)   cnt_q <= cnt_q - CNT_W'(1);
    end

    // Armed flag: set by a count write, cleared when the block completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         armed_q <= 1'b0;
        else if (wr_cnt)    armed_q <= 1'b1;
        else if (last_xfer) armed_q <= 1'b0;
    end

    // Done pulse: one cycle, suppressed when a count write re-arms the channel.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= last_xfer && !wr_cnt;
    end

    assign idx_o   = idx_q;
    assign mod_o   = mod_q;
    assign en_o    = en_q;
    assign armed_o = armed_q;
    assign done_o  = done_q;
endmodule

// File: rtl/dma_seq_arb.sv
// Module: fixed-priority arbiter over paired channels. Inside a pair the odd
// channel wins; a lower-numbered pair beats a higher one.
// Assumes: NCH is even. The grant is combinational and at most one bit is set.
module dma_seq_arb #(
    parameter int NCH  = 4,
    parameter int CH_W = 2
) (
    input  logic [NCH-1:0]  elig,
    output logic [NCH-1:0]  gnt,
    output logic            gnt_valid,
    output logic [CH_W-1:0] gnt_ch
);
    // Walk from lowest to highest priority; the last eligible hit wins.
    always_comb begin
        gnt = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            int ch;
            ch = k ^ 1;
            if (elig[ch]) begin
                gnt     = '0;
                gnt[ch] = 1'b1;
            end
        end
    end

    // Encode the one-hot grant into a channel number.
    always_comb begin
        gnt_ch = '0;
        for (int i = 0; i < NCH; i++)
            if (gnt[i]) gnt_ch = gnt_ch | CH_W'(i);
        gnt_valid = |gnt;
    end
endmodule

// File: rtl/dma_seq_addr.sv
// Module: selects the granted channel's index and adds the fixed base offset.
// Assumes: ADDR_W >= IDX_W. The index is already wrapped to IDX_W bits.
module dma_seq_addr #(
    parameter int              NCH       = 4,
    parameter int              CH_W      = 2,
    parameter int              IDX_W     = 19,
    parameter int              ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h8_0000
) (
    input  logic [NCH-1:0][IDX_W-1:0] idx_vec,
    input  logic [CH_W-1:0]           sel_ch,
    output logic [ADDR_W-1:0]         addr
);
    // Base plus the zero-extended index of the selected channel.
    always_comb addr = BASE_ADDR + ADDR_W'(idx_vec[sel_ch]);
endmodule

// File: rtl/dma_seq.sv
// Module: top of the DMA address and count sequencer. It joins the per-channel
// state, the pair-aware arbiter and the address generator.
// Assumes: NUM_PAIRS >= 1, so the channel count is even. Writes and requests
// are synchronous to clk.
module dma_seq
    import dma_seq_pkg::*;
#(
    parameter int                NUM_PAIRS = 2,
    parameter int                IDX_W     = 19,
    parameter int                MOD_W     = 16,
    parameter int                CNT_W     = 16,
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h8_0000,
    localparam int               NCH       = 2 * NUM_PAIRS,
    localparam int               CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  logic              wr_en,
    input  logic [CH_W-1:0]   wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [IDX_W-1:0]  wr_data,
    output logic              acc_valid,
    output logic [CH_W-1:0]   acc_ch,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [NCH-1:0]    done
);
    logic [NCH-1:0][IDX_W-1:0] idx_vec;
    logic [NCH-1:0][MOD_W-1:0] mod_vec;
    logic [NCH-1:0]            en_vec;
    logic [NCH-1:0]            armed_vec;
    logic [NCH-1:0]            elig;
    logic [NCH-1:0]            gnt;

    // A channel competes only when requested, enabled and armed.
    always_comb elig = req & en_vec & armed_vec;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            dma_seq_chan #(
                .IDX_W (IDX_W),
                .MOD_W (MOD_W),
                .CNT_W (CNT_W)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_hit  (wr_en && (wr_ch == CH_W'(c))),
                .wr_sel  (wr_sel),
                .wr_data (wr_data),
                .take    (gnt[c]),
                .idx_o   (idx_vec[c]),
                .mod_o   (mod_vec[c]),
                .en_o    (en_vec[c]),
                .armed_o (armed_vec[c]),
                .done_o  (done[c])
            );
        end
    endgenerate

    dma_seq_arb #(
        .NCH  (NCH),
        .CH_W (CH_W)
    ) u_arb (
        .elig      (elig),
        .gnt       (gnt),
        .gnt_valid (acc_valid),
        .gnt_ch    (acc_ch)
    );

    dma_seq_addr #(
        .NCH       (NCH),
        .CH_W      (CH_W),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr (
        .idx_vec (idx_vec),
        .sel_ch  (acc_ch),
        .addr    (acc_addr)
    );
endmodule

// File: rtl/dma_seq_checker.sv
// Module: assertion checker for dma_seq, attached with bind.
// Assumes: it sees the top's ports and its per-channel state vectors.
module dma_seq_checker
    import dma_seq_pkg::*;
#(
    parameter int                NCH       = 4,
    parameter int                CH_W      = 2,
    parameter int                IDX_W     = 19,
    parameter int                MOD_W     = 16,
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'h8_0000
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            req,
    input logic                      wr_en,
    input logic [CH_W-1:0]           wr_ch,
    input logic [1:0]                wr_sel,
    input logic                      acc_valid,
    input logic [CH_W-1:0]           acc_ch,
    input logic [ADDR_W-1:0]         acc_addr,
    input logic [NCH-1:0]            done,
    input logic [NCH-1:0][IDX_W-1:0] idx_vec,
    input logic [NCH-1:0][MOD_W-1:0] mod_vec,
    input logic [NCH-1:0]            en_vec,
    input logic [NCH-1:0]            armed_vec
);
    localparam int EXT_W = IDX_W - MOD_W;

    logic             prev_v;
    logic [CH_W-1:0]  prev_ch;
    logic [IDX_W-1:0] prev_exp;
    logic [ADDR_W-1:0] offs;

    // Remember the served channel and the index it should hold next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v   <= 1'b0;
            prev_ch  <= '0;
            prev_exp <= '0;
        end else begin
            prev_v   <= acc_valid &&
                        !(wr_en && (wr_ch == acc_ch) && (wr_sel == SEL_INDEX));
            prev_ch  <= acc_ch;
            prev_exp <= idx_vec[acc_ch] +
                        {{EXT_W{mod_vec[acc_ch][MOD_W-1]}}, mod_vec[acc_ch]};
        end
    end

    // Offset of the emitted address from the base.
    always_comb offs = acc_addr - BASE_ADDR;

    p_grant_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (req[acc_ch] && armed_vec[acc_ch]));

    p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> en_vec[acc_ch]);

    p_no_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> ((req & en_vec & armed_vec) == '0));

    p_addr_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (offs < (ADDR_W'(1) << IDX_W)));

    p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prev_v |-> (idx_vec[prev_ch] == prev_exp));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_done
            p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
                done[c] |=> !done[c]);
            p_done_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n)
                done[c] |-> !armed_vec[c]);
        end
    endgenerate
endmodule

bind dma_seq dma_seq_checker #(
    .NCH       (NCH),
    .CH_W      (CH_W),
    .IDX_W     (IDX_W),
    .MOD_W     (MOD_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .wr_en     (wr_en),
    .wr_ch     (wr_ch),
    .wr_sel    (wr_sel),
    .acc_valid (acc_valid),
    .acc_ch    (acc_ch),
    .acc_addr  (acc_addr),
    .done      (done),
    .idx_vec   (idx_vec),
    .mod_vec   (mod_vec),
    .en_vec    (en_vec),
    .armed_vec (armed_vec)
);

// File: tb/dma_seq_bench.sv
// Directed bench for dma_seq. Inputs change on the falling edge; outputs are
// sampled 2 ns later, before the next rising edge.
module dma_seq_bench;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  req = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_ch = '0;
    logic [1:0]      wr_sel = '0;
    logic [18:0]     wr_data = '0;
    logic            acc_valid;
    logic [1:0]      acc_ch;
    logic [19:0]     acc_addr;
    logic [NCH-1:0]  done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    dma_seq u_dma_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .acc_valid (acc_valid),
        .acc_ch    (acc_ch),
        .acc_addr  (acc_addr),
        .done      (done)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp<190000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = 19'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic prog(input int ch, input int idx, input int md, input int cnt, input int en);
        wr(ch, 0, idx);
        wr(ch, 1, md);
        wr(ch, 2, cnt);
        wr(ch, 3, en);
    endtask

    // Drive the request vector on this falling edge, then wait to sample.
    task automatic cyc(input logic [NCH-1:0] r);
        req = r;
        #2;
    endtask

    task automatic nxt(input logic [NCH-1:0] r);
        @(negedge clk);
        cyc(r);
    endtask

    task automatic t_reset();
        // R1: idle after reset, even with requests high.
        #2;
        chk("R1 acc_valid in reset", 32'(acc_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        cyc(4'hF);
        chk("R1 acc_valid after reset", 32'(acc_valid), 0);
        chk("R1 done after reset", 32'(done), 0);
        nxt(4'h0);
    endtask

    task automatic t_wrap_up();
        // R3/R2: index 0x7FFFE, modify +1, count 3.
        prog(1, 'h7FFFE, 1, 3, 1);
        cyc(4'b0010);
        chk("R2 valid", 32'(acc_valid), 1);
        chk("R2 channel", 32'(acc_ch), 1);
        chk("R3 addr 1", 32'(acc_addr), 'hFFFFE);
        nxt(4'b0010); chk("R3 addr 2", 32'(acc_addr), 'hFFFFF);
        nxt(4'b0010); chk("R3 wrapped addr", 32'(acc_addr), 'h80000);
        nxt(4'b0000);
    endtask

    task automatic t_wrap_down();
        // R4: index 5, modify 0xFFFE (-2), count 4.
        prog(0, 5, 'hFFFE, 4, 1);
        cyc(4'b0001); chk("R4 addr 1", 32'(acc_addr), 'h80005);
        nxt(4'b0001); chk("R4 addr 2", 32'(acc_addr), 'h80003);
        nxt(4'b0001); chk("R4 addr 3", 32'(acc_addr), 'h80001);
        nxt(4'b0001); chk("R4 wrapped addr", 32'(acc_addr), 'hFFFFF);
        nxt(4'b0000);
    endtask

    task automatic t_count_n();
        // R5: count 3 yields three accesses, then a one-cycle done.
        prog(3, 'h40, 2, 3, 1);
        cyc(4'b1000); chk("R5 addr 1", 32'(acc_addr), 'h80040);
        chk("R5 no early done", 32'(done), 0);
        nxt(4'b1000); chk("R5 addr 2", 32'(acc_addr), 'h80042);
        nxt(4'b1000); chk("R5 addr 3", 32'(acc_addr), 'h80044);
        nxt(4'b1000);
        chk("R5 done pulse", 32'(done), 'b1000);
        chk("R5 stopped after count", 32'(acc_valid), 0);
        nxt(4'b1000);
        chk("R5 done one cycle", 32'(done), 0);
        chk("R5 still stopped", 32'(acc_valid), 0);
        nxt(4'b0000);
    endtask

    task automatic t_count_zero();
        // R6: count 0 means 65536 accesses.
        int n = 0;
        int early = 0;
        prog(2, 0, 1, 0, 1);
        for (int i = 0; i < 65536; i++) begin
            if (i == 0) cyc(4'b0100); else nxt(4'b0100);
            if (acc_valid && acc_ch == 2'd2) n++;
            if (done != '0) early++;
        end
        chk("R6 access count", 32'(n), 65536);
        chk("R6 no early done", 32'(early), 0);
        nxt(4'b0100);
        chk("R6 done after 65536", 32'(done), 'b0100);
        chk("R6 stopped", 32'(acc_valid), 0);
        nxt(4'b0000);
    endtask

    task automatic t_disable();
        // R7: disabled channel ignores requests and keeps its state.
        prog(0, 'h100, 1, 2, 0);
        cyc(4'b0001); chk("R7 ignored 1", 32'(acc_valid), 0);
        nxt(4'b0001); chk("R7 ignored 2", 32'(acc_valid), 0);
        nxt(4'b0001); chk("R7 ignored 3", 32'(acc_valid), 0);
        req = '0;
        wr(0, 3, 1);
        cyc(4'b0001); chk("R7 index kept", 32'(acc_addr), 'h80100);
        nxt(4'b0001); chk("R7 second access", 32'(acc_addr), 'h80101);
        nxt(4'b0001); chk("R7 count kept", 32'(done), 'b0001);
        // Stop mid-block by clearing the enable bit.
        req = '0;
        prog(1, 'h20, 1, 50, 1);
        cyc(4'b0010); chk("R7 running", 32'(acc_valid), 1);
        req = '0;
        wr(1, 3, 0);
        cyc(4'b0010); chk("R7 stopped by enable", 32'(acc_valid), 0);
        nxt(4'b0000);
    endtask

    task automatic t_priority();
        // R8 and R9: order 1, 0, 3, 2.
        for (int c = 0; c < NCH; c++) prog(c, 'h10 * (c + 1), 1, 100, 1);
        cyc(4'b1111); chk("R8 odd wins pair 0", 32'(acc_ch), 1);
        nxt(4'b1101); chk("R9 pair 0 beats pair 1", 32'(acc_ch), 0);
        nxt(4'b1100); chk("R8 odd wins pair 1", 32'(acc_ch), 3);
        nxt(4'b0100); chk("R9 lowest priority", 32'(acc_ch), 2);
        nxt(4'b0011); chk("R8 ch1 over ch0", 32'(acc_ch), 1);
        req = '0;
        for (int c = 0; c < NCH; c++) wr(c, 3, 0);
    endtask

    task automatic t_write_override();
        // R10: write takes effect next cycle and beats the access update.
        prog(1, 'h10, 4, 10, 1);
        req = 4'b0010;
        wr_en = 1'b1; wr_ch = 2'd1; wr_sel = 2'd0; wr_data = 19'h200;
        #2; chk("R10 old index this cycle", 32'(acc_addr), 'h80010);
        @(negedge clk);
        wr_ch = 2'd1; wr_sel = 2'd2; wr_data = 19'd1;
        #2; chk("R10 written index wins", 32'(acc_addr), 'h80200);
        @(negedge clk);
        wr_en = 1'b0;
        #2; chk("R10 next addr", 32'(acc_addr), 'h80204);
        chk("R10 no done on rewrite", 32'(done), 0);
        nxt(4'b0010);
        chk("R10 written count wins", 32'(done), 'b0010);
        chk("R10 stopped", 32'(acc_valid), 0);
        nxt(4'b0000);
    endtask

    initial begin
        t_reset();
        t_wrap_up();
        t_wrap_down();
        t_count_n();
        t_disable();
        t_priority();
        t_write_override();
        t_count_zero();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule